// File: doc/BRIEF.md
# Packet Receive FIFO with Rollback

This block is a synchronous, byte-wide buffer between a receive MAC and a host reader. It stores whole packets only. A writer pushes the packet's bytes one at a time. It closes the packet with a commit strobe, and that strobe writes a status byte into the buffer as a tagged entry. The buffer keeps a committed pointer that marks the end of the last closed packet. The reader can only see entries below that pointer, so a packet becomes visible all at once, after its status entry has been stored.

When the writer decides a packet is bad, it raises the discard strobe. The write pointer then falls back to the committed pointer. This drops the partial packet and keeps every earlier closed packet intact. If no closed packet is held, the buffer ends up empty. An abort input clears the whole buffer, including closed packets. After an abort or a discard, the rest of the current frame is ignored until the carrier input changes level.

A write that finds the buffer full loses its data and raises a sticky overflow flag. The next rising carrier edge, which starts a new packet, clears that flag.

Top module: `pkt_rx_fifo`

## Requirements
- R1: After reset, `empty` is 1, `rd_valid` is 0 and `overflow` is 0.
- R2: Bytes of a packet not yet committed are never presented: `rd_valid` stays 0 until the commit, while `empty` reads 0 once any entry is stored.
- R3: A commit (`wr_commit`=1) stores `wr_data` as a status entry after the packet's bytes. The reader then receives the bytes in write order with `rd_status`=0, followed by the status byte with `rd_status`=1.
- R4: A discard (`wr_discard`=1) while no committed entry is held leaves the buffer empty (`empty`=1, `rd_valid`=0).
- R5: A discard while committed packets are held removes only the partial packet. The committed packets are then read back unchanged, and afterwards `empty` is 1.
- R6: After a discard, data writes and commits are ignored until `carrier` changes level. After that, writes are accepted again.
- R7: An abort clears every stored entry, committed or not. Data writes and commits are then ignored until `carrier` changes level, in either direction.
- R8: When `wr_commit` and `wr_discard` are high in the same cycle, the cycle acts as a discard.
- R9: A data write while DEPTH entries are stored (counted before any read in the same cycle) is dropped and sets `overflow`. `overflow` stays set until a rising edge of `carrier`. A falling edge does not clear it.
- R10: A commit while DEPTH entries are stored cannot store its status entry. It rolls the packet back to the committed pointer and sets `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | DATA_W | Packet byte, or status byte on a commit |
| wr_valid | input | 1 | Store `wr_data` as a packet byte |
| wr_commit | input | 1 | Close the packet by storing `wr_data` as its status entry |
| wr_discard | input | 1 | Drop the packet in progress |
| abort | input | 1 | Clear the whole buffer and ignore writes until a carrier change |
| carrier | input | 1 | Carrier / data-valid level from the line side |
| rd_data | output | DATA_W | Entry at the read pointer |
| rd_status | output | 1 | Entry at the read pointer is a status entry |
| rd_valid | output | 1 | A committed entry is available |
| rd_ready | input | 1 | Reader takes the entry |
| overflow | output | 1 | Sticky: a write was lost because the buffer was full |
| empty | output | 1 | No entry stored, committed or not |

## Verification
Commit and discard can arrive in the same cycle. The bench raises both strobes on one edge after a partial packet and expects an empty buffer with nothing readable, which is how a discard ends. A full buffer meeting a commit is a second collision: the bench fills all DEPTH slots with one uncommitted packet, then commits. It expects the rollback to leave the buffer empty with `overflow` set, and it checks that only a rising carrier edge clears the flag.

// File: rtl/pkt_rx_fifo_pkg.sv
package pkt_rx_fifo_pkg;

   // Write-side operation after strobe precedence is applied
   typedef enum logic [1:0] {
      WOP_IDLE   = 2'd0,
      WOP_DATA   = 2'd1,
      WOP_CLOSE  = 2'd2,
      WOP_DROP   = 2'd3
   } wop_e;

   // Drop outranks close, close outranks a plain byte
   function automatic wop_e wop_decode(input logic valid, input logic close, input logic drop);
      if (drop)       return WOP_DROP;
      else if (close) return WOP_CLOSE;
      else if (valid) return WOP_DATA;
      else            return WOP_IDLE;
   endfunction

endpackage

// File: rtl/rbf_store.sv
module rbf_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [DATA_W:0]          wentry,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [DATA_W:0]          rentry
);
   localparam int EW = DATA_W + 1;

   logic [DEPTH-1:0][EW-1:0] rows;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      logic [EW-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (we && (waddr == g[$clog2(DEPTH)-1:0])) cell_q <= wentry;
      end
      assign rows[g] = cell_q;
   end

   assign rentry = rows[raddr];
endmodule

// File: rtl/rbf_ptrs.sv
module rbf_ptrs
   import pkt_rx_fifo_pkg::*;
#(
   parameter int DEPTH = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  wop_e                     op,
   input  logic                     abort,
   input  logic                     hold,
   input  logic                     rd_fire,
   output logic                     we,
   output logic [$clog2(DEPTH)-1:0] waddr,
   output logic                     wstat,
   output logic                     ovf_evt,
   output logic                     rd_valid,
   output logic                     empty,
   output logic [$clog2(DEPTH)-1:0] raddr
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   logic [PW-1:0] w_q, c_q, r_q;
   logic [PW-1:0] fill, readable;
   logic          full, take_data, take_close;

   assign fill       = w_q - r_q;
   assign readable   = c_q - r_q;
   assign full       = (fill == PW'(DEPTH));
   assign take_data  = (op == WOP_DATA)  && !hold && !abort;
   assign take_close = (op == WOP_CLOSE) && !hold && !abort;

   assign we       = (take_data || take_close) && !full;
   assign wstat    = take_close;
   assign ovf_evt  = (take_data || take_close) && full;
   assign waddr    = w_q[AW-1:0];
   assign raddr    = r_q[AW-1:0];
   assign rd_valid = (c_q != r_q);
   assign empty    = (w_q == r_q);

   always_ff @(posedge clk) begin
      if (!rst_n || abort) begin
         w_q <= '0;
         c_q <= '0;
         r_q <= '0;
      end else begin
         if (rd_fire) r_q <= r_q + 1'b1;
         if (op == WOP_DROP) begin
            w_q <= c_q;
         end else if (take_close) begin
            if (full) begin
               w_q <= c_q;
            end else begin
               w_q <= w_q + 1'b1;
               c_q <= w_q + 1'b1;
            end
         end else if (take_data && !full) begin
            w_q <= w_q + 1'b1;
         end
      end
   end

   // R2
   commit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      readable <= fill);

   // R4
   drop_rollback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == WOP_DROP && !abort) |=> (w_q == c_q));

   // R7
   abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (empty && !rd_valid));

   // R6
   hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !abort && op != WOP_DROP) |=> $stable(w_q));
endmodule

// File: rtl/rbf_gate.sv
module rbf_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic carrier,
   input  logic abort,
   input  logic drop,
   input  logic ovf_evt,
   output logic hold,
   output logic overflow
);
   logic car_q, hold_q, ovf_q;
   logic car_edge, car_rise;

   assign car_edge = carrier ^ car_q;
   assign car_rise = carrier & ~car_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         car_q  <= 1'b0;
         hold_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         car_q <= carrier;
         if (abort || drop)  hold_q <= 1'b1;
         else if (car_edge)  hold_q <= 1'b0;
         if (ovf_evt)        ovf_q  <= 1'b1;
         else if (car_rise)  ovf_q  <= 1'b0;
      end
   end

   assign hold     = hold_q;
   assign overflow = ovf_q;

   // R9
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> overflow);

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !car_rise) |=> overflow);
endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo
   import pkt_rx_fifo_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_valid,
   input  logic              wr_commit,
   input  logic              wr_discard,
   input  logic              abort,
   input  logic              carrier,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_status,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic              overflow,
   output logic              empty
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pkt_rx_fifo: DEPTH must be a power of two of at least 4");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("pkt_rx_fifo: DATA_W must be at least 1");
   end

   wop_e            op;
   logic            hold, we, wstat, ovf_evt, rd_fire;
   logic [AW-1:0]   waddr, raddr;
   logic [DATA_W:0] rentry;

   assign op      = wop_decode(wr_valid, wr_commit, wr_discard);
   assign rd_fire = rd_valid && rd_ready && !abort;

   rbf_gate u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .carrier  (carrier),
      .abort    (abort),
      .drop     (op == WOP_DROP),
      .ovf_evt  (ovf_evt),
      .hold     (hold),
      .overflow (overflow)
   );

   rbf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .abort    (abort),
      .hold     (hold),
      .rd_fire  (rd_fire),
      .we       (we),
      .waddr    (waddr),
      .wstat    (wstat),
      .ovf_evt  (ovf_evt),
      .rd_valid (rd_valid),
      .empty    (empty),
      .raddr    (raddr)
   );

   rbf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk    (clk),
      .we     (we),
      .waddr  (waddr),
      .wentry ({wstat, wr_data}),
      .raddr  (raddr),
      .rentry (rentry)
   );

   assign rd_data   = rentry[DATA_W-1:0];
   assign rd_status = rentry[DATA_W];

   // R2
   valid_implies_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !empty);
endmodule

// File: tb/tb_pkt_rx_fifo.sv
module tb_pkt_rx_fifo;
   localparam int CLK_P  = 10;
   localparam int DATA_W = 8;
   localparam int DEPTH  = 64;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [DATA_W-1:0] wr_data;
   logic              wr_valid, wr_commit, wr_discard, abort, carrier, rd_ready;
   logic [DATA_W-1:0] rd_data;
   logic              rd_status, rd_valid, overflow, empty;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   pkt_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_valid(wr_valid),
      .wr_commit(wr_commit), .wr_discard(wr_discard), .abort(abort),
      .carrier(carrier), .rd_data(rd_data), .rd_status(rd_status),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .overflow(overflow), .empty(empty)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] b);
      wr_data = b; wr_valid = 1'b1; tick(); wr_valid = 1'b0;
   endtask

   task automatic close_pkt(input logic [7:0] s);
      wr_data = s; wr_commit = 1'b1; tick(); wr_commit = 1'b0;
   endtask

   task automatic drop_pkt();
      wr_discard = 1'b1; tick(); wr_discard = 1'b0;
   endtask

   task automatic flip_carrier();
      carrier = ~carrier; tick();
   endtask

   task automatic pop(input string req, input logic [7:0] d, input logic st);
      check(req, "rd_valid before pop", int'(rd_valid), 1);
      check(req, "rd_data", int'(rd_data), int'(d));
      check(req, "rd_status", int'(rd_status), int'(st));
      rd_ready = 1'b1; tick(); rd_ready = 1'b0;
   endtask

   task automatic t_reset();
      check("R1", "empty after reset", int'(empty), 1);
      check("R1", "rd_valid after reset", int'(rd_valid), 0);
      check("R1", "overflow after reset", int'(overflow), 0);
   endtask

   task automatic t_basic();
      push(8'h11); push(8'h22); push(8'h33);
      check("R2", "rd_valid with open packet", int'(rd_valid), 0);
      check("R2", "empty with open packet", int'(empty), 0);
      close_pkt(8'hA5);
      pop("R3", 8'h11, 1'b0); pop("R3", 8'h22, 1'b0); pop("R3", 8'h33, 1'b0);
      pop("R3", 8'hA5, 1'b1);
      check("R3", "rd_valid after packet", int'(rd_valid), 0);
      check("R3", "empty after packet", int'(empty), 1);
   endtask

   task automatic t_drop_lone();
      push(8'h01); push(8'h02);
      drop_pkt();
      check("R4", "empty after lone discard", int'(empty), 1);
      check("R4", "rd_valid after lone discard", int'(rd_valid), 0);
      push(8'h44);
      check("R6", "byte ignored while held", int'(empty), 1);
      close_pkt(8'h4F);
      check("R6", "commit ignored while held", int'(rd_valid), 0);
      flip_carrier();
      push(8'h55); close_pkt(8'h5A);
      pop("R6", 8'h55, 1'b0); pop("R6", 8'h5A, 1'b1);
      check("R6", "empty after release", int'(empty), 1);
   endtask

   task automatic t_drop_keep();
      push(8'h61); push(8'h62); close_pkt(8'hC1);
      push(8'h71); push(8'h72); push(8'h73);
      drop_pkt();
      pop("R5", 8'h61, 1'b0); pop("R5", 8'h62, 1'b0); pop("R5", 8'hC1, 1'b1);
      check("R5", "rd_valid after kept packet", int'(rd_valid), 0);
      check("R5", "empty after kept packet", int'(empty), 1);
      flip_carrier();
   endtask

   task automatic t_both();
      push(8'h81);
      wr_data = 8'h8F; wr_commit = 1'b1; wr_discard = 1'b1; tick();
      wr_commit = 1'b0; wr_discard = 1'b0;
      check("R8", "empty after commit+discard", int'(empty), 1);
      check("R8", "rd_valid after commit+discard", int'(rd_valid), 0);
      flip_carrier();
   endtask

   task automatic t_abort();
      push(8'h91); close_pkt(8'h9F); push(8'h92);
      check("R7", "packet readable before abort", int'(rd_valid), 1);
      abort = 1'b1; tick(); abort = 1'b0;
      check("R7", "empty after abort", int'(empty), 1);
      check("R7", "rd_valid after abort", int'(rd_valid), 0);
      push(8'h93); close_pkt(8'h9E);
      check("R7", "writes ignored after abort", int'(empty), 1);
      check("R7", "carrier high before falling release", int'(carrier), 1);
      flip_carrier();
      push(8'h94); close_pkt(8'h9D);
      pop("R7", 8'h94, 1'b0); pop("R7", 8'h9D, 1'b1);
   endtask

   task automatic fill_full();
      for (int i = 0; i < DEPTH; i++) push(8'(i));
   endtask

   task automatic t_overflow();
      fill_full();
      check("R9", "overflow at exactly DEPTH", int'(overflow), 0);
      check("R9", "data not readable while open", int'(rd_valid), 0);
      push(8'hEE);
      check("R9", "overflow on write when full", int'(overflow), 1);
      close_pkt(8'hEF);
      check("R10", "commit when full rolls back", int'(empty), 1);
      check("R10", "commit when full not readable", int'(rd_valid), 0);
      check("R10", "overflow after full commit", int'(overflow), 1);
      check("R9", "carrier low before rise", int'(carrier), 0);
      flip_carrier();
      check("R9", "rising carrier clears overflow", int'(overflow), 0);
      fill_full();
      push(8'hEE);
      check("R9", "overflow set again", int'(overflow), 1);
      drop_pkt();
      flip_carrier();
      check("R9", "falling carrier keeps overflow", int'(overflow), 1);
      push(8'hB1); close_pkt(8'hB2);
      pop("R9", 8'hB1, 1'b0); pop("R9", 8'hB2, 1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wr_data = '0; wr_valid = 1'b0; wr_commit = 1'b0;
      wr_discard = 1'b0; abort = 1'b0; carrier = 1'b0; rd_ready = 1'b0;
      @(negedge clk); tick(); tick();
      rst_n = 1'b1; tick();
      t_reset();
      t_basic();
      t_drop_lone();
      t_drop_keep();
      t_both();
      t_abort();
      t_overflow();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule